// File: doc/BRIEF.md
# Atomic Notification Counter Line

This block is a single synchronization word that lives next to a scratchpad and gives software a hardware completion detector. Software first programs it: a starting count, a notification word, up to four notification addresses, and a mask saying which of those addresses are live. From then on, every store to the add offset is not a plain write: the stored value, read as a two's-complement number, is added to the count in one step. Stores can therefore count up or count down.

When an add moves the count from a nonzero value to zero, the line sends the programmed notification word to each live address. The writes go out one at a time on a valid/ready request port, lowest slot first. A set of producers that each add their share, or a barrier where each arrival adds minus one, then signals its completion without any polling. While the fan-out is in progress, any store to the line is refused through a stall output. The writer holds its store until the stall drops.

Top module: `notify_counter_line`

## Requirements
- R1: After reset the count reads 0, `ntf_valid` is low and `wr_stall` is low.
- R2: An accepted write at word offset 0 replaces the count with `wr_data` and never starts a notification, even when the value written is zero.
- R3: An accepted write at word offset 1 sets the count to the old count plus `wr_data`, modulo 2^DATA_W. This covers wrap-around and negative addends.
- R4: When an accepted add takes the count from nonzero to zero, `ntf_valid` rises in the next cycle. Each request carries the notification word, which is written at offset 2.
- R5: Requests go out in ascending slot order and skip every slot whose mask bit is clear. Slot i's mask bit is bit i of the word written at offset 3. Slot i's address is written at offset 4+i.
- R6: Each request is retired by exactly one cycle with `ntf_valid` and `ntf_ready` both high. While `ntf_ready` is low, the request's address and data hold steady. After the last live slot is accepted, no further request appears.
- R7: If the mask is all zeros when the count reaches zero, no request is issued.
- R8: While requests are pending, any store sees `wr_stall` high in the same cycle and has no effect on the line's state.
- R9: An add that leaves the count nonzero, or an add to a count that is already zero, issues no request.
- R10: `cnt_value` always shows the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Store request to the line |
| wr_ofs | input | OFS_W | Word offset inside the line |
| wr_data | input | DATA_W | Store data |
| wr_stall | output | 1 | Store refused this cycle; hold and retry |
| ntf_valid | output | 1 | Notification request present |
| ntf_ready | input | 1 | Receiver takes the request |
| ntf_addr | output | ADDR_W | Destination of the notification |
| ntf_data | output | DATA_W | Notification word |
| cnt_value | output | DATA_W | Current count |

## Verification
The bench uses the default build: 32-bit data and addresses, four slots, and a three-bit offset. This makes the 32-bit wrap from all-ones to zero reachable by a single add. It also makes every mask pattern over the four slots reachable, including gaps, a single slot and an empty mask. A long random phase keeps counts small and addends within plus or minus two, so zero crossings happen often. A random ready line stretches each fan-out so that the stall and hold behaviour gets exercised.

// File: rtl/ncl_pkg.sv
`timescale 1ns/1ps
package ncl_pkg;
    // Word offsets inside the line
    localparam int OFS_COUNT = 0;  // overwrite the count
    localparam int OFS_ADD   = 1;  // atomic add
    localparam int OFS_WORD  = 2;  // notification word
    localparam int OFS_MASK  = 3;  // slot live bits
    localparam int OFS_ADDR0 = 4;  // first slot address
endpackage

// File: rtl/ncl_slot_pick.sv
`timescale 1ns/1ps
// Lowest-index pick among pending slots
module ncl_slot_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign gnt[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ncl_addr_bank.sv
`timescale 1ns/1ps
// Notification destination registers, one per slot
module ncl_addr_bank #(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         sel,
    input  logic [ADDR_W-1:0]        wdata,
    output logic [N-1:0][ADDR_W-1:0] addr
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [ADDR_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q <= '0;
            else if (we && sel == IDX_W'(g))     slot_q <= wdata;
        end
        assign addr[g] = slot_q;
    end
endmodule

// File: rtl/notify_counter_line.sv
`timescale 1ns/1ps
module notify_counter_line
    import ncl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int N_SLOTS = 4,
    parameter int OFS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stall,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [ADDR_W-1:0] ntf_addr,
    output logic [DATA_W-1:0] ntf_data,
    output logic [DATA_W-1:0] cnt_value
);
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    typedef struct packed {
        logic [DATA_W-1:0]  cnt;
        logic [DATA_W-1:0]  word;
        logic [N_SLOTS-1:0] mask;
        logic [N_SLOTS-1:0] pend;
    } line_st_t;

    line_st_t s_q, s_d;

    logic                      busy, acc, is_add, fire;
    logic [DATA_W-1:0]         sum;
    logic [N_SLOTS-1:0]        grant;
    logic [IDX_W-1:0]          gidx;
    logic                      bank_we;
    logic [IDX_W-1:0]          bank_sel;
    logic [N_SLOTS-1:0][ADDR_W-1:0] bank_addr;

    ncl_slot_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .req (s_q.pend),
        .gnt (grant),
        .idx (gidx)
    );

    ncl_addr_bank #(.N(N_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .sel   (bank_sel),
        .wdata (wr_data[ADDR_W-1:0]),
        .addr  (bank_addr)
    );

    always_comb begin
        busy     = |s_q.pend;
        acc      = wr_en && !busy;
        is_add   = acc && (wr_ofs == OFS_W'(OFS_ADD));
        sum      = s_q.cnt + wr_data;
        fire     = is_add && (s_q.cnt != '0) && (sum == '0);

        bank_we  = 1'b0;
        bank_sel = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (acc && wr_ofs == OFS_W'(OFS_ADDR0 + i)) begin
                bank_we  = 1'b1;
                bank_sel = IDX_W'(i);
            end
        end

        s_d = s_q;
        if (acc) begin
            if (wr_ofs == OFS_W'(OFS_COUNT))     s_d.cnt  = wr_data;
            else if (is_add)                     s_d.cnt  = sum;
            else if (wr_ofs == OFS_W'(OFS_WORD)) s_d.word = wr_data;
            else if (wr_ofs == OFS_W'(OFS_MASK)) s_d.mask = wr_data[N_SLOTS-1:0];
        end

        if (fire)                   s_d.pend = s_q.mask;
        else if (busy && ntf_ready) s_d.pend = s_q.pend & ~grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_stall  = wr_en && busy;
    assign ntf_valid = busy;
    assign ntf_addr  = bank_addr[gidx];
    assign ntf_data  = s_q.word;
    assign cnt_value = s_q.cnt;
endmodule

// File: rtl/ncl_checker.sv
`timescale 1ns/1ps
module ncl_checker
    import ncl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int N_SLOTS = 4,
    parameter int OFS_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [OFS_W-1:0]  wr_ofs,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_stall,
    input logic              ntf_valid,
    input logic              ntf_ready,
    input logic [ADDR_W-1:0] ntf_addr,
    input logic [DATA_W-1:0] ntf_data,
    input logic [DATA_W-1:0] cnt_value
);
    logic              c_acc, c_add, c_cfg;
    logic [DATA_W-1:0] c_sum;
    logic [N_SLOTS-1:0] shadow_mask;

    assign c_acc = wr_en && !wr_stall;
    assign c_add = c_acc && wr_ofs == OFS_W'(OFS_ADD);
    assign c_cfg = c_acc && wr_ofs == OFS_W'(OFS_COUNT);
    assign c_sum = cnt_value + wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_mask <= '0;
        else if (c_acc && wr_ofs == OFS_W'(OFS_MASK)) shadow_mask <= wr_data[N_SLOTS-1:0];
    end

    AST_CFG_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_cfg |=> (cnt_value == $past(wr_data)) && !ntf_valid); // R2
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        c_add |=> cnt_value == $past(c_sum)); // R3
    AST_ZERO_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_add && cnt_value != '0 && c_sum == '0 && shadow_mask != '0) |=> ntf_valid); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && !ntf_ready) |=> ntf_valid && $stable(ntf_addr) && $stable(ntf_data)); // R6
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (c_add && shadow_mask == '0) |=> !ntf_valid); // R7
    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && wr_en) |-> wr_stall); // R8
    AST_STALL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |=> $stable(cnt_value)); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_add && (cnt_value == '0 || c_sum != '0)) |=> !ntf_valid); // R9
endmodule

bind notify_counter_line ncl_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS), .OFS_W(OFS_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .wr_stall(wr_stall), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
    .ntf_addr(ntf_addr), .ntf_data(ntf_data), .cnt_value(cnt_value)
);

// File: tb/test_notify_counter_line.sv
`timescale 1ns/1ps
module test_notify_counter_line;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ofs = '0;
    logic [31:0] wr_data = '0;
    logic        wr_stall;
    logic        ntf_valid;
    logic        ntf_ready = 1'b0;
    logic [31:0] ntf_addr;
    logic [31:0] ntf_data;
    logic [31:0] cnt_value;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_cnt = '0;
    logic [31:0] m_word = '0;
    logic [3:0]  m_mask = '0;
    logic [31:0] m_addr [4];

    always #5 clk = ~clk;

    notify_counter_line i_notify_counter_line (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .wr_stall(wr_stall), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
        .ntf_addr(ntf_addr), .ntf_data(ntf_data), .cnt_value(cnt_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit model_write(input logic [2:0] ofs, input logic [31:0] d);
        logic [31:0] old;
        bit fired;
        fired = 1'b0;
        case (ofs)
            3'd0: m_cnt = d;
            3'd1: begin old = m_cnt; m_cnt = old + d; fired = (old != 0) && (m_cnt == 0); end
            3'd2: m_word = d;
            3'd3: m_mask = d[3:0];
            default: m_addr[ofs - 3'd4] = d;
        endcase
        return fired;
    endfunction

    // Store with stall handling; returns at the negedge after acceptance
    task automatic wr(input logic [2:0] ofs, input logic [31:0] d, output bit fired);
        @(negedge clk);
        wr_en = 1'b1; wr_ofs = ofs; wr_data = d;
        #1;
        while (wr_stall) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        fired = model_write(ofs, d);
    endtask

    task automatic expect_fanout(input bit fired);
        int exp_slots[$];
        int k = 0;
        int guard = 0;
        if (fired) for (int i = 0; i < 4; i++) if (m_mask[i]) exp_slots.push_back(i);
        while (k < exp_slots.size() && guard < 100) begin
            ntf_ready = ($urandom % 3) != 0;
            #1;
            if (!ntf_valid) begin
                chk(1'b0, "R4 request missing", 32'd0, 32'd1);
                k = exp_slots.size();
            end else if (ntf_ready) begin
                chk(ntf_addr == m_addr[exp_slots[k]], "R5 slot order/address", ntf_addr, m_addr[exp_slots[k]]);
                chk(ntf_data == m_word, "R4 notification word", ntf_data, m_word);
                k++;
            end
            @(negedge clk);
            guard++;
        end
        ntf_ready = 1'b0;
        #1;
        chk(!ntf_valid, fired ? "R6 no extra request" : "R9 no request", 32'(ntf_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit f;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        repeat (3) @(negedge clk);
        chk(cnt_value == 0, "R1 count after reset", cnt_value, 0);
        chk(!ntf_valid, "R1 valid after reset", 32'(ntf_valid), 0);
        chk(!wr_stall, "R1 stall after reset", 32'(wr_stall), 0);
        rst_n = 1'b1;

        // Configuration
        wr(3'd2, 32'hCAFE_0001, f);
        wr(3'd3, 32'h0000_000B, f);
        for (int i = 0; i < 4; i++) wr(3'(4 + i), 32'h1000 + 32'(i) * 32'h10, f);
        wr(3'd0, 32'd0, f);
        chk(cnt_value == 0, "R2 zero overwrite", cnt_value, 0);
        expect_fanout(1'b0);
        wr(3'd0, 32'd3, f);
        chk(cnt_value == 3, "R2 overwrite", cnt_value, 3);
        expect_fanout(1'b0);

        // Barrier countdown, slots 0,1,3 live
        wr(3'd1, 32'hFFFF_FFFF, f);
        chk(cnt_value == 2, "R3 negative add", cnt_value, 2);
        expect_fanout(f);
        wr(3'd1, 32'hFFFF_FFFF, f);
        expect_fanout(f);
        wr(3'd1, 32'hFFFF_FFFF, f);
        chk(f && cnt_value == 0, "R4 reaches zero", cnt_value, 0);
        // Stalled store during fan-out
        ntf_ready = 1'b0;
        wr_en = 1'b1; wr_ofs = 3'd0; wr_data = 32'd5;
        #1;
        chk(wr_stall, "R8 stall while busy", 32'(wr_stall), 1);
        @(negedge clk);
        wr_en = 1'b0;
        chk(cnt_value == 0, "R8 stalled store ignored", cnt_value, 0);
        expect_fanout(f);
        chk(cnt_value == 0, "R8 count after fan-out", cnt_value, 0);

        // Add zero to zero
        wr(3'd1, 32'd0, f);
        chk(!f && cnt_value == 0, "R9 zero plus zero", cnt_value, 0);
        expect_fanout(f);

        // Wrap
        wr(3'd0, 32'hFFFF_FFFF, f);
        wr(3'd1, 32'd2, f);
        chk(cnt_value == 1, "R3 wrap", cnt_value, 1);
        expect_fanout(f);
        wr(3'd1, 32'hFFFF_FFFF, f);
        chk(f, "R4 fire after wrap path", cnt_value, 0);
        expect_fanout(f);

        // Empty mask
        wr(3'd3, 32'd0, f);
        wr(3'd0, 32'd1, f);
        wr(3'd1, 32'hFFFF_FFFF, f);
        chk(cnt_value == 0, "R7 count zero", cnt_value, 0);
        expect_fanout(1'b0);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [2:0] o;
            logic [31:0] d;
            op = $urandom % 10;
            if (op < 2)      begin o = 3'd0; d = $urandom_range(0, 4); end
            else if (op < 7) begin o = 3'd1; d = 32'($signed($urandom_range(0, 4)) - 2); end
            else if (op < 8) begin o = 3'd3; d = $urandom; end
            else if (op < 9) begin o = 3'd2; d = $urandom; end
            else             begin o = 3'(4 + ($urandom % 4)); d = $urandom; end
            wr(o, d, f);
            chk(cnt_value == m_cnt, "R10 count tracks model", cnt_value, m_cnt);
            expect_fanout(f);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule